// File: doc/BRIEF.md
# Ring Gate Access Checker

This block judges each memory access or control transfer issued by code running in one of four privilege rings, where ring 0 is the most trusted (kernel), ring 1 carries operating system services, ring 2 carries trusted applications and ring 3 carries untrusted applications. For every request it receives the ring of the running code, the target segment and that segment's ring, the kind of access, and the target offset. One cycle later it reports whether the request is allowed, which ring the code runs in afterwards, and a fault code that says why a request was refused.

Data reads and writes may only reach segments of the same or a less trusted ring. A call into a more trusted ring is accepted only when its offset is one of the entry points registered for that segment. These entry points live in a small per-segment table of gate offsets, and only ring 0 code can change that table. An accepted call moves the code into the target segment's ring.

Top module: `ring_gate_guard`

## Requirements
- R1: After reset rsp_valid, rsp_allow and rsp_fault are 0 and the gate table holds no valid entry, so an inward call at any offset is refused with fault 1.
- R2: A response (rsp_valid high) appears on the clock edge after each cycle with req_valid high, and rsp_valid is low after every cycle with req_valid low.
- R3: Read (req_kind 0) and write (req_kind 1) are allowed when req_seg_ring is numerically greater than or equal to req_cur_ring; otherwise they are refused with fault 2.
- R4: Execute (req_kind 2) is allowed only when req_seg_ring equals req_cur_ring; otherwise it is refused with fault 3.
- R5: A call (req_kind 3) to a segment whose ring number is greater than or equal to req_cur_ring is allowed and rsp_ring becomes req_seg_ring.
- R6: A call to a segment of lower ring number is allowed only when req_off equals the offset of a valid gate entry of segment req_seg; it then returns rsp_ring equal to req_seg_ring. Any of the GATES_PER_SEG slots, including the last, can hold such an entry.
- R7: An inward call at an offset not registered for that segment is refused with fault 1.
- R8: A gate table write (gw_valid) takes effect on the next edge only when gw_ring is 0; a write with any other gw_ring leaves the table unchanged.
- R9: A refused request returns rsp_ring equal to its req_cur_ring; an allowed request returns fault 0; read, write and execute that are allowed return rsp_ring equal to req_cur_ring.
- R10: Gate entries belong to one segment only, and writing a slot with gw_enable 0 removes its entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present this cycle |
| req_cur_ring | input | RING_W | Ring of the running code |
| req_seg | input | SEG_W | Target segment number |
| req_seg_ring | input | RING_W | Ring of the target segment |
| req_kind | input | 2 | 0 read, 1 write, 2 execute, 3 call |
| req_off | input | OFF_W | Target offset within the segment |
| gw_valid | input | 1 | Gate table write request |
| gw_ring | input | RING_W | Ring of the code doing the write |
| gw_seg | input | SEG_W | Segment whose gate slot is written |
| gw_slot | input | SLOT_W | Slot index within the segment |
| gw_off | input | OFF_W | Entry offset stored in the slot |
| gw_enable | input | 1 | 1 registers the entry, 0 removes it |
| rsp_valid | output | 1 | Response present |
| rsp_allow | output | 1 | Request allowed |
| rsp_ring | output | RING_W | Ring after the request |
| rsp_fault | output | 2 | 0 none, 1 bad gate offset, 2 data privilege, 3 execute ring mismatch |

## Verification
The only internal state is the gate table, so a corrupt entry shows up as an inward call that is wrongly accepted or wrongly refused on the response one edge after the call is issued. A lost or misdirected table write therefore becomes visible at the first call to the affected segment and offset, which the bench issues right after each write. A wrong decision path shows up the same cycle at rsp_allow, rsp_ring and rsp_fault, and is checked for every access kind on both sides of the ring comparison.

// File: rtl/ring_gate_pkg.sv
package ring_gate_pkg;

   typedef enum logic [1:0] {
      ACC_READ  = 2'd0,
      ACC_WRITE = 2'd1,
      ACC_EXEC  = 2'd2,
      ACC_CALL  = 2'd3
   } acc_kind_e;

   typedef enum logic [1:0] {
      FLT_NONE = 2'd0,
      FLT_GATE = 2'd1,
      FLT_DATA = 2'd2,
      FLT_EXEC = 2'd3
   } fault_e;

endpackage

// File: rtl/gate_table.sv
module gate_table #(
   parameter int NUM_SEGS = 8,
   parameter int GATES    = 8,
   parameter int OFF_W    = 8,
   localparam int SEG_W   = $clog2(NUM_SEGS),
   localparam int SLOT_W  = $clog2(GATES)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [SEG_W-1:0]  wr_seg,
   input  logic [SLOT_W-1:0] wr_slot,
   input  logic [OFF_W-1:0]  wr_off,
   input  logic              wr_keep,
   input  logic [SEG_W-1:0]  lk_seg,
   input  logic [OFF_W-1:0]  lk_off,
   output logic              lk_hit
);

   logic [GATES-1:0] ent_vld [NUM_SEGS];
   logic [OFF_W-1:0] ent_off [NUM_SEGS][GATES];
   logic [GATES-1:0] slot_hit;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int s = 0; s < NUM_SEGS; s++) ent_vld[s] <= '0;
      end else if (wr_en) begin
         ent_vld[wr_seg][wr_slot] <= wr_keep;
      end
   end

   always_ff @(posedge clk) begin
      if (wr_en) ent_off[wr_seg][wr_slot] <= wr_off;
   end

   for (genvar g = 0; g < GATES; g++) begin : g_cmp
      assign slot_hit[g] = ent_vld[lk_seg][g] && (ent_off[lk_seg][g] == lk_off);
   end

   assign lk_hit = |slot_hit;

endmodule

// File: rtl/ring_rules.sv
module ring_rules
   import ring_gate_pkg::*;
#(
   parameter int RING_W = 2
) (
   input  logic [RING_W-1:0] cur_ring,
   input  logic [RING_W-1:0] seg_ring,
   input  acc_kind_e         kind,
   input  logic              gate_hit,
   output logic              allow,
   output logic [RING_W-1:0] next_ring,
   output fault_e            fault
);

   logic outward_or_same;
   assign outward_or_same = (seg_ring >= cur_ring);

   always_comb begin
      allow     = 1'b0;
      next_ring = cur_ring;
      fault     = FLT_NONE;
      unique case (kind)
         ACC_READ, ACC_WRITE: begin
            if (outward_or_same) allow = 1'b1;
            else                 fault = FLT_DATA;
         end
         ACC_EXEC: begin
            if (seg_ring == cur_ring) allow = 1'b1;
            else                      fault = FLT_EXEC;
         end
         ACC_CALL: begin
            if (outward_or_same || gate_hit) begin
               allow     = 1'b1;
               next_ring = seg_ring;
            end else begin
               fault = FLT_GATE;
            end
         end
         default: fault = FLT_NONE;
      endcase
   end

endmodule

// File: rtl/ring_gate_guard.sv
module ring_gate_guard
   import ring_gate_pkg::*;
#(
   parameter int NUM_RINGS     = 4,
   parameter int NUM_SEGS      = 8,
   parameter int GATES_PER_SEG = 8,
   parameter int OFF_W         = 8,
   localparam int RING_W       = $clog2(NUM_RINGS),
   localparam int SEG_W        = $clog2(NUM_SEGS),
   localparam int SLOT_W       = $clog2(GATES_PER_SEG)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic [RING_W-1:0] req_cur_ring,
   input  logic [SEG_W-1:0]  req_seg,
   input  logic [RING_W-1:0] req_seg_ring,
   input  logic [1:0]        req_kind,
   input  logic [OFF_W-1:0]  req_off,
   input  logic              gw_valid,
   input  logic [RING_W-1:0] gw_ring,
   input  logic [SEG_W-1:0]  gw_seg,
   input  logic [SLOT_W-1:0] gw_slot,
   input  logic [OFF_W-1:0]  gw_off,
   input  logic              gw_enable,
   output logic              rsp_valid,
   output logic              rsp_allow,
   output logic [RING_W-1:0] rsp_ring,
   output logic [1:0]        rsp_fault
);

   if (NUM_RINGS < 2 || (1 << RING_W) != NUM_RINGS) begin : g_bad_rings
      $error("NUM_RINGS must be a power of two, at least 2");
   end
   if (NUM_SEGS < 2 || (1 << SEG_W) != NUM_SEGS) begin : g_bad_segs
      $error("NUM_SEGS must be a power of two, at least 2");
   end
   if (GATES_PER_SEG < 2 || (1 << SLOT_W) != GATES_PER_SEG) begin : g_bad_gates
      $error("GATES_PER_SEG must be a power of two, at least 2");
   end
   if (OFF_W < 1) begin : g_bad_off
      $error("OFF_W must be positive");
   end

   logic              tbl_we;
   logic              gate_hit;
   logic              dec_allow;
   logic [RING_W-1:0] dec_ring;
   fault_e            dec_fault;

   // only the most trusted ring may edit entry points
   assign tbl_we = gw_valid && (gw_ring == '0);

   gate_table #(
      .NUM_SEGS (NUM_SEGS),
      .GATES    (GATES_PER_SEG),
      .OFF_W    (OFF_W)
   ) u_table (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (tbl_we),
      .wr_seg  (gw_seg),
      .wr_slot (gw_slot),
      .wr_off  (gw_off),
      .wr_keep (gw_enable),
      .lk_seg  (req_seg),
      .lk_off  (req_off),
      .lk_hit  (gate_hit)
   );

   ring_rules #(
      .RING_W (RING_W)
   ) u_rules (
      .cur_ring  (req_cur_ring),
      .seg_ring  (req_seg_ring),
      .kind      (acc_kind_e'(req_kind)),
      .gate_hit  (gate_hit),
      .allow     (dec_allow),
      .next_ring (dec_ring),
      .fault     (dec_fault)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rsp_valid <= 1'b0;
         rsp_allow <= 1'b0;
         rsp_ring  <= '0;
         rsp_fault <= FLT_NONE;
      end else begin
         rsp_valid <= req_valid;
         if (req_valid) begin
            rsp_allow <= dec_allow;
            rsp_ring  <= dec_ring;
            rsp_fault <= dec_fault;
         end
      end
   end

endmodule

// File: rtl/ring_gate_guard_chk.sv
module ring_gate_guard_chk #(
   parameter int RING_W = 2
) (
   input logic              clk,
   input logic              rst_n,
   input logic              req_valid,
   input logic [RING_W-1:0] req_cur_ring,
   input logic [RING_W-1:0] req_seg_ring,
   input logic [1:0]        req_kind,
   input logic              rsp_valid,
   input logic              rsp_allow,
   input logic [RING_W-1:0] rsp_ring,
   input logic [1:0]        rsp_fault
);

   AST_RSP_FOLLOWS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |=> rsp_valid); // R2
   AST_NO_SPURIOUS_RSP: assert property (@(posedge clk) disable iff (!rst_n)
      !req_valid |=> !rsp_valid); // R2
   AST_DATA_OK: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && !req_kind[1] && req_seg_ring >= req_cur_ring) |=> rsp_allow); // R3
   AST_DATA_DENY: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && !req_kind[1] && req_seg_ring < req_cur_ring)
      |=> (!rsp_allow && rsp_fault == 2'd2)); // R3
   AST_EXEC_MISMATCH: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_kind == 2'd2 && req_seg_ring != req_cur_ring)
      |=> (!rsp_allow && rsp_fault == 2'd3)); // R4
   AST_OUTWARD_CALL: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_kind == 2'd3 && req_seg_ring >= req_cur_ring)
      |=> (rsp_allow && rsp_ring == $past(req_seg_ring))); // R5
   AST_GAIN_ONLY_BY_CALL: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_kind != 2'd3) |=> (rsp_ring == $past(req_cur_ring))); // R9
   AST_GATE_FAULT_DENIES: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && rsp_fault == 2'd1) |-> !rsp_allow); // R7
   AST_ALLOW_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && rsp_allow) |-> rsp_fault == 2'd0); // R9
   AST_DENY_KEEPS_RING: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid) |=> (rsp_allow || rsp_ring == $past(req_cur_ring))); // R9

endmodule

bind ring_gate_guard ring_gate_guard_chk #(.RING_W(RING_W)) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .req_valid    (req_valid),
   .req_cur_ring (req_cur_ring),
   .req_seg_ring (req_seg_ring),
   .req_kind     (req_kind),
   .rsp_valid    (rsp_valid),
   .rsp_allow    (rsp_allow),
   .rsp_ring     (rsp_ring),
   .rsp_fault    (rsp_fault)
);

// File: tb/tb_ring_gate_guard.sv
module tb_ring_gate_guard;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       req_valid = 1'b0;
   logic [1:0] req_cur_ring = '0;
   logic [2:0] req_seg = '0;
   logic [1:0] req_seg_ring = '0;
   logic [1:0] req_kind = '0;
   logic [7:0] req_off = '0;
   logic       gw_valid = 1'b0;
   logic [1:0] gw_ring = '0;
   logic [2:0] gw_seg = '0;
   logic [2:0] gw_slot = '0;
   logic [7:0] gw_off = '0;
   logic       gw_enable = 1'b0;
   logic       rsp_valid;
   logic       rsp_allow;
   logic [1:0] rsp_ring;
   logic [1:0] rsp_fault;

   int n_chk = 0;
   int n_err = 0;

   always #2 clk = ~clk;

   ring_gate_guard dut (
      .clk(clk), .rst_n(rst_n),
      .req_valid(req_valid), .req_cur_ring(req_cur_ring), .req_seg(req_seg),
      .req_seg_ring(req_seg_ring), .req_kind(req_kind), .req_off(req_off),
      .gw_valid(gw_valid), .gw_ring(gw_ring), .gw_seg(gw_seg), .gw_slot(gw_slot),
      .gw_off(gw_off), .gw_enable(gw_enable),
      .rsp_valid(rsp_valid), .rsp_allow(rsp_allow), .rsp_ring(rsp_ring),
      .rsp_fault(rsp_fault)
   );

   task automatic check(string req, int act, int exp);
      n_chk++;
      if (act != exp) begin
         n_err++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   // issue one request, then check the registered response
   task automatic access(string req, int cur, int seg, int sring, int kind, int off,
                         int exp_allow, int exp_ring, int exp_fault);
      @(negedge clk);
      req_valid = 1'b1; req_cur_ring = 2'(cur); req_seg = 3'(seg);
      req_seg_ring = 2'(sring); req_kind = 2'(kind); req_off = 8'(off);
      @(negedge clk);
      req_valid = 1'b0;
      check({req, " valid"}, int'(rsp_valid), 1);
      check({req, " allow"}, int'(rsp_allow), exp_allow);
      check({req, " ring"},  int'(rsp_ring),  exp_ring);
      check({req, " fault"}, int'(rsp_fault), exp_fault);
   endtask

   task automatic gate_write(int wring, int seg, int slot, int off, int en);
      @(negedge clk);
      gw_valid = 1'b1; gw_ring = 2'(wring); gw_seg = 3'(seg);
      gw_slot = 3'(slot); gw_off = 8'(off); gw_enable = en[0];
      @(negedge clk);
      gw_valid = 1'b0;
   endtask

   task automatic t_reset();
      check("R1 rsp_valid", int'(rsp_valid), 0);
      check("R1 rsp_allow", int'(rsp_allow), 0);
      check("R1 rsp_fault", int'(rsp_fault), 0);
      access("R1 empty table", 3, 0, 0, 3, 0, 0, 3, 1);
   endtask

   task automatic t_data();
      access("R3 read outward", 1, 2, 2, 0, 5, 1, 1, 0);
      access("R3 write same",   2, 2, 2, 1, 5, 1, 2, 0);
      access("R3 write inward", 2, 1, 1, 1, 5, 0, 2, 2);
      access("R3 read kernel",  3, 0, 0, 0, 5, 0, 3, 2);
   endtask

   task automatic t_exec();
      access("R4 exec same",    1, 3, 1, 2, 9, 1, 1, 0);
      access("R4 exec outward", 0, 3, 2, 2, 9, 0, 0, 3);
      access("R4 exec inward",  3, 3, 1, 2, 9, 0, 3, 3);
   endtask

   task automatic t_outward_call();
      access("R5 call outward", 1, 6, 3, 3, 17, 1, 3, 0);
      access("R5 call same",    2, 6, 2, 3, 17, 1, 2, 0);
   endtask

   task automatic t_gates();
      gate_write(2, 5, 0, 8'h40, 1);
      access("R8 write from ring2 ignored", 3, 5, 0, 3, 8'h40, 0, 3, 1);
      gate_write(0, 5, 0, 8'h40, 1);
      access("R6 gate call", 3, 5, 0, 3, 8'h40, 1, 0, 0);
      access("R7 bad offset", 3, 5, 0, 3, 8'h41, 0, 3, 1);
      access("R10 other seg", 2, 4, 1, 3, 8'h40, 0, 2, 1);
      gate_write(0, 5, 7, 8'hFF, 1);
      access("R6 last slot", 2, 5, 1, 3, 8'hFF, 1, 1, 0);
      gate_write(0, 5, 0, 8'h40, 0);
      access("R10 cleared entry", 3, 5, 0, 3, 8'h40, 0, 3, 1);
      access("R10 sibling kept", 3, 5, 0, 3, 8'hFF, 1, 0, 0);
   endtask

   task automatic t_idle();
      @(negedge clk);
      check("R2 no request", int'(rsp_valid), 0);
      access("R9 deny keeps ring", 1, 0, 0, 0, 0, 0, 1, 2);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_data();
      t_exec();
      t_outward_call();
      t_gates();
      t_idle();
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end

   initial begin
      #100000;
      n_chk++;
      n_err++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end

endmodule